// File: doc/BRIEF.md
# Descriptor-driven configuration DMA engine

The engine moves bytes of a selected configuration item into system memory under the control of a descriptor that software leaves in memory. Software writes the 64-bit memory address of a 16-byte descriptor into the engine's address register. The engine then reads the descriptor, optionally selects a new item, and either copies item bytes to a target address or advances past them. When it is done it writes a status word back over the descriptor's control field. Reads of the address register return a fixed 8-byte signature, so software can probe for the engine.

The descriptor is big-endian throughout. It holds a 32-bit control word at byte 0, a 32-bit length at byte 4 and a 64-bit target address at byte 8. The engine reaches memory through a byte-wide request/acknowledge master port that can flag an error. It reads item contents through a byte port that is addressed by the engine's own item offset.

The state machine runs through the following states. IDLE waits for a trigger. FETCH_REQ/FETCH_WAIT read the 16 descriptor bytes. DECODE picks the operation. SELECT pulses the item select. MOVE/MOVE_WAIT copy, zero-fill or skip. STATUS_REQ/STATUS_WAIT write back the four status bytes.

The transitions are:
- IDLE→FETCH_REQ on a trigger.
- FETCH_REQ→FETCH_WAIT.
- FETCH_WAIT→FETCH_REQ on a good byte that is not the last one.
- FETCH_WAIT→DECODE on the last good byte.
- FETCH_WAIT→STATUS_REQ on a fetch error.
- DECODE→SELECT when the select bit is set, otherwise DECODE→MOVE.
- SELECT→MOVE.
- MOVE→MOVE_WAIT for a read byte.
- MOVE→MOVE for a skip step.
- MOVE→STATUS_REQ when the length is used up.
- MOVE_WAIT→MOVE on a good write.
- MOVE_WAIT→STATUS_REQ on a write error.
- STATUS_REQ→STATUS_WAIT.
- STATUS_WAIT→STATUS_REQ for the next status byte.
- STATUS_WAIT→IDLE after the fourth status byte.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, `busy` is low, no memory request is issued and `item_off` is 0.
- R2: A register read of `reg_size` bytes (1, 2, 4 or 8) at `reg_off` returns signature bytes off..off+size-1, taking byte 0 as the most significant byte of SIGNATURE. The bytes are packed big-endian into the low bits of `reg_rdata`. An illegal size, or an access that runs past byte 7, reads 0.
- R3: While idle, a 4-byte write at offset 0 loads the high address half and clears the low half. A 4-byte write at offset 4 ORs the low half in and starts a transfer. An 8-byte write at offset 0 loads the whole address and starts a transfer. Every other size or offset has no effect. The latched address returns to 0 when a transfer starts.
- R4: A transfer first reads the 16 descriptor bytes in ascending address order, starting at the descriptor address. The layout is control = bytes 0..3, length = bytes 4..7 and target = bytes 8..15, each field big-endian.
- R5: Control bit 1 (0x02) selects a read even when bit 2 (0x04, skip) is also set. Bit 2 alone selects a skip. With neither bit set, the length is treated as 0 and nothing moves.
- R6: When control bit 3 (0x08) is set, `item_sel` pulses for one cycle with `item_key` = control bits 31:16, and the item offset returns to 0. The item side presents `item_ok`/`item_len` from the following cycle on.
- R7: A read copies item bytes starting at the current offset to ascending target addresses, advancing both the offset and the target address by one per byte.
- R8: Once the offset reaches `item_len`, or when `item_ok` is low, a read writes 0 for each remaining byte and the offset stays put.
- R9: A skip advances the offset by min(length, bytes left in the item) and issues no memory writes other than the status word.
- R10: A memory error on a data write stops the transfer at once, and the status reports the error bit.
- R11: A memory error while fetching the descriptor writes the status word 0x00000001 and does nothing else: no select and no data writes.
- R12: On completion, the four control bytes of the descriptor are rewritten big-endian as 0x00000000 on success or 0x00000001 on error, and `busy` then drops.
- R13: Any register write made while `busy` is high is ignored and does not start a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Address register write strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature read data, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Response for the outstanding request |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| item_sel | output | 1 | One-cycle item select pulse |
| item_key | output | 16 | Key of the item being selected |
| item_ok | input | 1 | Current selection is valid |
| item_len | input | 32 | Length of the current item |
| item_off | output | 32 | Current item byte offset |
| item_byte | input | 8 | Item byte at item_off |

## Verification
The bench uses the default 64-bit signature and a small item model with nine keys. Keys 0..7 have lengths 0, 3, ..., 21, and key 8 is invalid but reports a non-zero length. The bench sweeps every key against eight lengths from 0 to 23 and all four read/skip bit combinations, so that each transfer straddles the item end in both directions. A follow-up read without select exposes the offset left behind. Separate scenarios place the target and the descriptor in memory windows that fault on writes or on reads, and probe every register size and offset pairing.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    localparam int DESC_BYTES   = 16;
    localparam int STATUS_BYTES = 4;
    localparam int FIELD_W      = 32;
    localparam int DADDR_W      = 64;
    localparam int IDX_W        = $clog2(DESC_BYTES);

    // control word bit positions
    localparam int CB_ERR  = 0;
    localparam int CB_READ = 1;
    localparam int CB_SKIP = 2;
    localparam int CB_SEL  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_SELECT,
        ST_MOVE,
        ST_MOVE_WAIT,
        ST_STATUS_REQ,
        ST_STATUS_WAIT
    } dma_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_SKIP
    } dma_op_e;

endpackage

// File: rtl/cfg_dma_trigger.sv
module cfg_dma_trigger
    import cfg_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_off,
    input  logic [3:0]         reg_size,
    input  logic [63:0]        reg_wdata,
    input  logic               busy,
    output logic               start,
    output logic [DADDR_W-1:0] start_addr
);

    localparam int HALF_W = DADDR_W / 2;

    logic [DADDR_W-1:0] addr_q;
    logic               wr_hi;
    logic               wr_lo;
    logic               wr_full;

    always_comb begin
        wr_hi   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd0);
        wr_lo   = reg_wr && !busy && (reg_size == 4'd4) && (reg_off == 3'd4);
        wr_full = reg_wr && !busy && (reg_size == 4'd8) && (reg_off == 3'd0);
        start   = wr_lo || wr_full;
        if (wr_full) begin
            start_addr = reg_wdata;
        end else begin
            start_addr = addr_q | {{HALF_W{1'b0}}, reg_wdata[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (start) begin
            addr_q <= '0;
        end else if (wr_hi) begin
            addr_q <= {reg_wdata[HALF_W-1:0], {HALF_W{1'b0}}};
        end
    end

endmodule

// File: rtl/cfg_dma_sig.sv
module cfg_dma_sig #(
    parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_2121
) (
    input  logic [2:0]  reg_off,
    input  logic [3:0]  reg_size,
    output logic [63:0] reg_rdata
);

    logic [3:0]  end_b;
    logic [3:0]  tail_b;
    logic [6:0]  shamt;
    logic [63:0] shifted;
    logic        legal;

    always_comb begin
        end_b   = {1'b0, reg_off} + reg_size;
        tail_b  = 4'd8 - end_b;
        shamt   = {tail_b[3:0], 3'b000};
        shifted = SIGNATURE >> shamt;
        legal   = (end_b <= 4'd8);
        reg_rdata = '0;
        if (legal) begin
            case (reg_size)
                4'd1:    reg_rdata = {56'b0, shifted[7:0]};
                4'd2:    reg_rdata = {48'b0, shifted[15:0]};
                4'd4:    reg_rdata = {32'b0, shifted[31:0]};
                4'd8:    reg_rdata = shifted;
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_dma_core.sv
module cfg_dma_core
    import cfg_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DADDR_W-1:0] start_addr,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic [7:0]         mem_rdata,
    output logic               item_sel,
    output logic [15:0]        item_key,
    input  logic               item_ok,
    input  logic [FIELD_W-1:0] item_len,
    output logic [FIELD_W-1:0] item_off,
    input  logic [7:0]         item_byte
);

    localparam int SR_W = 8 * DESC_BYTES;

    dma_state_e          state_q, state_d;
    dma_op_e             op_q;
    logic [IDX_W-1:0]    idx_q;
    logic [SR_W-1:0]     desc_q;
    logic [DADDR_W-1:0]  base_q;
    logic [DADDR_W-1:0]  tgt_q;
    logic [FIELD_W-1:0]  remain_q;
    logic [FIELD_W-1:0]  off_q;
    logic                err_q;

    logic [FIELD_W-1:0]  ctrl_w;
    logic [FIELD_W-1:0]  len_w;
    logic [DADDR_W-1:0]  tgt_w;
    logic                in_item;
    logic [FIELD_W-1:0]  item_rem;
    logic [FIELD_W-1:0]  skip_n;
    logic                fetch_last;
    logic                status_last;

    always_comb begin
        ctrl_w      = desc_q[SR_W-1 -: FIELD_W];
        len_w       = desc_q[SR_W-FIELD_W-1 -: FIELD_W];
        tgt_w       = desc_q[DADDR_W-1:0];
        in_item     = item_ok && (off_q < item_len);
        item_rem    = item_len - off_q;
        skip_n      = (in_item && (item_rem < remain_q)) ? item_rem : remain_q;
        fetch_last  = (idx_q == IDX_W'(DESC_BYTES - 1));
        status_last = (idx_q == IDX_W'(STATUS_BYTES - 1));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ:   state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT:  if (mem_ack) begin
                                if (mem_err)         state_d = ST_STATUS_REQ;
                                else if (fetch_last) state_d = ST_DECODE;
                                else                 state_d = ST_FETCH_REQ;
                            end
            ST_DECODE:      state_d = ctrl_w[CB_SEL] ? ST_SELECT : ST_MOVE;
            ST_SELECT:      state_d = ST_MOVE;
            ST_MOVE:        if (remain_q == '0)     state_d = ST_STATUS_REQ;
                            else if (op_q == OP_READ) state_d = ST_MOVE_WAIT;
            ST_MOVE_WAIT:   if (mem_ack) state_d = mem_err ? ST_STATUS_REQ : ST_MOVE;
            ST_STATUS_REQ:  state_d = ST_STATUS_WAIT;
            ST_STATUS_WAIT: if (mem_ack) state_d = status_last ? ST_IDLE : ST_STATUS_REQ;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            idx_q    <= '0;
            desc_q   <= '0;
            base_q   <= '0;
            tgt_q    <= '0;
            remain_q <= '0;
            off_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q <= start_addr;
                    idx_q  <= '0;
                    err_q  <= 1'b0;
                end
                ST_FETCH_WAIT: if (mem_ack) begin
                    if (mem_err) begin
                        err_q <= 1'b1;
                        idx_q <= '0;
                    end else begin
                        desc_q <= {desc_q[SR_W-9:0], mem_rdata};
                        idx_q  <= idx_q + 1'b1;
                    end
                end
                ST_DECODE: begin
                    tgt_q <= tgt_w;
                    if (ctrl_w[CB_READ]) begin
                        op_q     <= OP_READ;
                        remain_q <= len_w;
                    end else if (ctrl_w[CB_SKIP]) begin
                        op_q     <= OP_SKIP;
                        remain_q <= len_w;
                    end else begin
                        op_q     <= OP_NONE;
                        remain_q <= '0;
                    end
                end
                ST_SELECT: off_q <= '0;
                ST_MOVE: begin
                    if (remain_q == '0) begin
                        idx_q <= '0;
                    end else if (op_q != OP_READ) begin
                        remain_q <= remain_q - skip_n;
                        tgt_q    <= tgt_q + DADDR_W'(skip_n);
                        if (in_item) off_q <= off_q + skip_n;
                    end
                end
                ST_MOVE_WAIT: if (mem_ack) begin
                    if (mem_err) begin
                        err_q <= 1'b1;
                        idx_q <= '0;
                    end else begin
                        remain_q <= remain_q - 1'b1;
                        tgt_q    <= tgt_q + 1'b1;
                        if (in_item) off_q <= off_q + 1'b1;
                    end
                end
                ST_STATUS_WAIT: if (mem_ack) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q + DADDR_W'(idx_q);
        mem_wdata = '0;
        item_sel  = 1'b0;
        item_key  = ctrl_w[FIELD_W-1 -: 16];
        item_off  = off_q;
        unique case (state_q)
            ST_FETCH_REQ:  mem_req = 1'b1;
            ST_SELECT:     item_sel = 1'b1;
            ST_MOVE: if (op_q == OP_READ && remain_q != '0) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tgt_q;
                mem_wdata = in_item ? item_byte : 8'h00;
            end
            ST_STATUS_REQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = status_last ? {7'b0, err_q} : 8'h00;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
    import cfg_dma_pkg::*;
#(
    parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_2121
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_off,
    input  logic [3:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [7:0]  mem_rdata,
    output logic        item_sel,
    output logic [15:0] item_key,
    input  logic        item_ok,
    input  logic [31:0] item_len,
    output logic [31:0] item_off,
    input  logic [7:0]  item_byte
);

    logic               start;
    logic [DADDR_W-1:0] start_addr;

    cfg_dma_trigger trig_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_off    (reg_off),
        .reg_size   (reg_size),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .start      (start),
        .start_addr (start_addr)
    );

    cfg_dma_sig #(.SIGNATURE(SIGNATURE)) sig_i (
        .reg_off   (reg_off),
        .reg_size  (reg_size),
        .reg_rdata (reg_rdata)
    );

    cfg_dma_core core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .item_sel   (item_sel),
        .item_key   (item_key),
        .item_ok    (item_ok),
        .item_len   (item_len),
        .item_off   (item_off),
        .item_byte  (item_byte)
    );

endmodule

// File: rtl/cfg_dma_engine_chk.sv
module cfg_dma_engine_chk #(
    parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_2121
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_off,
    input logic [3:0]  reg_size,
    input logic [63:0] reg_rdata,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        item_sel
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !item_sel));

    // R2
    sig_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_size == 4'd1 && reg_off == 3'd0) |-> reg_rdata == {56'b0, SIGNATURE[63:56]});

    // R3
    low_half_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd4) |=> busy);

    // R3
    bad_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && !(reg_size == 4'd4 && reg_off == 3'd4)
                         && !(reg_size == 4'd8 && reg_off == 3'd0)) |=> !busy);

    // R4
    fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we));

    // R4
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R6
    select_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        item_sel |=> !item_sel);

endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.SIGNATURE(SIGNATURE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_off   (reg_off),
    .reg_size  (reg_size),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .item_sel  (item_sel)
);

// File: tb/cfg_dma_engine_tb_top.sv
`timescale 1ns/1ps
module cfg_dma_engine_tb_top;

    localparam logic [63:0] SIG = 64'h4346_4744_4D41_2121;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [3:0]  reg_size = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        item_sel;
    logic [15:0] item_key;
    logic        item_ok;
    logic [31:0] item_len;
    logic [31:0] item_off;
    logic [7:0]  item_byte;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfg_dma_engine #(.SIGNATURE(SIG)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .item_sel(item_sel), .item_key(item_key),
        .item_ok(item_ok), .item_len(item_len), .item_off(item_off),
        .item_byte(item_byte)
    );

    // item model
    function automatic logic [7:0] item_val(int k, int o);
        return 8'((k * 16 + o * 7 + 1) & 255);
    endfunction
    function automatic int item_size(int k);
        return (k < 8) ? 3 * k : 0;
    endfunction

    logic [15:0] key_q = 16'd0;
    assign item_ok   = (key_q < 16'd8);
    assign item_len  = item_ok ? 32'(3 * int'(key_q)) : 32'd9;
    assign item_byte = item_val(int'(key_q), int'(item_off));

    // memory model
    logic [7:0]  mem [256];
    logic        pend = 1'b0;
    logic        p_we = 1'b0;
    logic [7:0]  p_addr = '0;
    logic [7:0]  p_wdata = '0;
    logic        arm_first = 1'b0;
    logic [63:0] first_addr = '0;
    int          wr_cnt = 0;
    int          sel_cnt = 0;
    int          rises = 0;
    logic        prev_busy = 1'b0;

    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (pend) begin
            mem_ack = 1'b1;
            if (p_we) begin
                wr_cnt++;
                if (p_addr >= 8'hD0 && p_addr <= 8'hDF) mem_err = 1'b1;
                else mem[p_addr] = p_wdata;
            end else begin
                if (p_addr >= 8'hC0 && p_addr <= 8'hCF) mem_err = 1'b1;
                mem_rdata = mem[p_addr];
            end
        end
        pend    = mem_req;
        p_we    = mem_we;
        p_addr  = mem_addr[7:0];
        p_wdata = mem_wdata;
        if (mem_req && arm_first) begin
            first_addr = mem_addr;
            arm_first  = 1'b0;
        end
        if (item_sel) begin
            sel_cnt++;
            key_q = item_key;
        end
        if (busy && !prev_busy) rises++;
        prev_busy = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int off, input int size, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = 3'(off); reg_size = 4'(size); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[8'(a + i)] = v[31 - 8 * i -: 8];
    endtask

    task automatic put_desc(input int a, input logic [31:0] ctl,
                            input logic [31:0] len, input logic [63:0] tgt);
        put32(a, ctl);
        put32(a + 4, len);
        put32(a + 8, tgt[63:32]);
        put32(a + 12, tgt[31:0]);
    endtask

    function automatic logic [31:0] get32(input int a);
        return {mem[8'(a)], mem[8'(a + 1)], mem[8'(a + 2)], mem[8'(a + 3)]};
    endfunction

    task automatic start_full(input logic [63:0] a);
        arm_first = 1'b1;
        reg_write(0, 8, a);
    endtask

    task automatic start_halves(input logic [31:0] hi, input logic [31:0] lo);
        reg_write(0, 4, {32'b0, hi});
        arm_first = 1'b1;
        reg_write(4, 4, {32'b0, lo});
    endtask

    // one swept pair: selected transfer A, then plain read B
    task automatic run_pair(input int k, input int len, input int op, input int mode);
        logic [31:0] opbits;
        int il, off0, bad_i;
        logic [7:0] e, got;
        string tag;
        il = item_size(k);
        opbits = (op == 1) ? 32'h2 : (op == 2) ? 32'h4 : (op == 3) ? 32'h6 : 32'h0;
        tag = (op == 0) ? "R5" : (op == 2) ? "R9" : "R7 R8";
        for (int i = 0; i < 32; i++) mem[8'(8'h40 + i)] = 8'hA5;
        for (int i = 0; i < 4; i++) mem[8'(8'h80 + i)] = 8'hA5;
        put_desc(8'h00, (32'(k) << 16) | 32'h8 | opbits, 32'(len), 64'h40);
        put_desc(8'h10, 32'h2, 32'd3, 64'h80);
        wr_cnt = 0;
        if (mode == 0) start_halves(32'h0, 32'h0);
        else           start_full(64'h0);
        wait_done();
        bad_i = -1; e = 0; got = 0;
        for (int i = 0; i <= len; i++) begin
            logic [7:0] x;
            if (op == 1 || op == 3) x = (i < len) ? ((i < il) ? item_val(k, i) : 8'h00) : 8'hA5;
            else x = 8'hA5;
            if (mem[8'(8'h40 + i)] !== x && bad_i < 0) begin
                bad_i = i; e = x; got = mem[8'(8'h40 + i)];
            end
        end
        chk(bad_i < 0, tag, $sformatf("target k=%0d len=%0d op=%0d byte %0d", k, len, op, bad_i),
            longint'(got), longint'(e));
        chk(get32(0) == 32'h0, "R12", "status A", longint'(get32(0)), 0);
        if (op == 0 || op == 2)
            chk(wr_cnt == 4, (op == 0) ? "R5" : "R9", "write count", wr_cnt, 4);
        off0 = (op != 0 && k < 8) ? ((len < il) ? len : il) : 0;
        start_full(64'h10);
        wait_done();
        bad_i = -1; e = 0; got = 0;
        for (int j = 0; j < 4; j++) begin
            logic [7:0] x;
            if (j < 3) x = (k < 8 && off0 + j < il) ? item_val(k, off0 + j) : 8'h00;
            else x = 8'hA5;
            if (mem[8'(8'h80 + j)] !== x && bad_i < 0) begin
                bad_i = j; e = x; got = mem[8'(8'h80 + j)];
            end
        end
        chk(bad_i < 0, (op == 2) ? "R9" : "R6", $sformatf("offset follow-up k=%0d len=%0d op=%0d byte %0d",
            k, len, op, bad_i), longint'(got), longint'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lens[8];
        lens = '{0, 1, 2, 3, 5, 8, 13, 23};
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", longint'({busy, mem_req}), 0);
        chk(item_off == 32'd0, "R1", "item_off after reset", longint'(item_off), 0);

        // R2 signature sweep
        for (int s = 0; s < 9; s++) begin
            for (int o = 0; o < 8; o++) begin
                logic [63:0] exp;
                exp = '0;
                if ((s == 1 || s == 2 || s == 4 || s == 8) && o + s <= 8)
                    for (int b = 0; b < s; b++) exp = (exp << 8) | 64'(SIG[63 - 8 * (o + b) -: 8]);
                reg_off = 3'(o); reg_size = 4'(s);
                #1;
                chk(reg_rdata == exp, "R2", $sformatf("sig size %0d off %0d", s, o),
                    longint'(reg_rdata), longint'(exp));
            end
        end

        // R3 rejected writes
        put_desc(8'h60, 32'h0, 32'd0, 64'h0);
        begin
            int r0;
            r0 = rises;
            reg_write(0, 2, 64'h60);
            reg_write(2, 4, 64'h60);
            reg_write(4, 1, 64'h60);
            reg_write(4, 8, 64'h60);
            reg_write(1, 8, 64'h60);
            repeat (3) @(negedge clk);
            chk(rises == r0 && !busy, "R3", "rejected writes start nothing", rises - r0, 0);
        end

        // R3 R4 halves and latch clearing
        start_halves(32'h1, 32'h60);
        wait_done();
        chk(first_addr == 64'h1_0000_0060, "R3", "two-half address", longint'(first_addr), 64'h1_0000_0060);
        arm_first = 1'b1;
        reg_write(4, 4, 64'h60);
        wait_done();
        chk(first_addr == 64'h60, "R3", "latch cleared on start", longint'(first_addr), 64'h60);
        chk(get32(8'h60) == 32'h0, "R12", "status after no-op", longint'(get32(8'h60)), 0);

        // main sweep
        for (int k = 0; k < 9; k++)
            for (int li = 0; li < 8; li++)
                for (int op = 0; op < 4; op++)
                    run_pair(k, lens[li], op, (k + li + op) % 2);

        // R10 write error mid-transfer
        mem[8'hCE] = 8'h00; mem[8'hCF] = 8'h00;
        put_desc(8'h20, 32'h0007_000A, 32'd5, 64'hCE);
        start_full(64'h20);
        wait_done();
        chk(mem[8'hCE] == item_val(7, 0) && mem[8'hCF] == item_val(7, 1), "R10", "bytes before error",
            longint'({mem[8'hCE], mem[8'hCF]}), longint'({item_val(7, 0), item_val(7, 1)}));
        chk(get32(8'h20) == 32'h1, "R10", "error status", longint'(get32(8'h20)), 1);

        // R11 descriptor fetch error
        put32(8'hC4, 32'hFFFF_000A);
        wr_cnt = 0;
        sel_cnt = 0;
        start_full(64'hC4);
        wait_done();
        chk(get32(8'hC4) == 32'h1, "R11", "fetch error status", longint'(get32(8'hC4)), 1);
        chk(wr_cnt == 4 && sel_cnt == 0, "R11", "no other activity", longint'({wr_cnt, sel_cnt}), 64'h4_0000_0000);

        // R13 triggers while busy are ignored
        for (int i = 0; i < 32; i++) mem[8'(8'h40 + i)] = 8'hA5;
        put_desc(8'h00, 32'h0007_000A, 32'd23, 64'h40);
        begin
            int r0;
            r0 = rises;
            start_full(64'h0);
            repeat (5) @(negedge clk);
            reg_write(4, 4, 64'h10);
            reg_write(0, 8, 64'h10);
            wait_done();
            repeat (4) @(negedge clk);
            chk(rises == r0 + 1 && !busy, "R13", "one transfer only", rises - r0, 1);
            chk(mem[8'h40 + 21] == 8'h00 && mem[8'h40 + 20] == item_val(7, 20), "R13",
                "busy transfer intact", longint'(mem[8'h40 + 20]), longint'(item_val(7, 20)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule